// File: doc/BRIEF.md
# Management Data Command Register Engine

This block is a single 32-bit command register that launches one Clause 22 management frame on a two-wire MDC/MDIO bus each time the host writes it with the top bit set. The write carries direction, PHY address, PHY register address and, for writes, the 16-bit payload. The engine serialises the frame, releases the data line for the turnaround and data phases of a read, samples the returned bits, and places them in the low half of the same register.

Bit 31 is both the start trigger and the busy flag. Hardware clears it when the frame is over, so software writes a command and then polls the register until bit 31 reads 0; at that point a read result is waiting in bits 15:0. While bit 31 is set, further host writes are dropped. MDC comes from the system clock through a parameterised divider and toggles only while a frame is in flight.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the register reads 0x00000000, MDC is low and MDIO is released (mdio_oe = 0); whenever bit 31 reads 0, MDC is low and MDIO is released.
- R2: A host write with bit 31 = 1, made while bit 31 reads 0, makes bit 31 read 1 from the next cycle until the frame ends, and then 0.
- R3: Command fields are: bit 30 direction (1 = write, 0 = read), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 write payload.
- R4: Each frame, seen on rising MDC edges, is 32 ones, start bits 0 then 1, opcode 0 then 1 for a write or 1 then 0 for a read, then the 5 PHY address bits and the 5 register address bits, most significant bit first, for 64 bits in all.
- R5: A write frame drives turnaround 1 then 0, then the 16 payload bits MSB first; after completion the register reads the written word with bit 31 cleared (0xC0A09000 puts 0x9000 into register 0 of PHY 5; 0xC0C09000 does the same to PHY 6).
- R6: A read frame releases MDIO for both turnaround bits and all 16 data bits, samples MDIO on each rising MDC of the data phase MSB first, and on completion returns those bits in bits 15:0 with bits 30:16 kept as written.
- R7: Host writes while bit 31 reads 1 are ignored: the register and the frame in flight are unchanged.
- R8: A host write with bit 31 = 0 stores the word and starts no frame (MDC stays low).
- R9: MDC has a period of 2*HALF_DIV system clocks during a frame, and MDIO and its enable change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command register |
| wr_data | input | 32 | Host write word |
| rd_data | output | 32 | Current register contents (busy flag, fields, read result) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data drive enable (0 = released) |
| mdio_i | input | 1 | Management data sampled value |

## Verification
A bit counter off by one shows as a frame whose bits land shifted against the expected 64-bit pattern, or as the busy flag dropping a bit period early or late, so it shows up within the first frame. A wrong direction or field decode shows as a wrong opcode, address or drive-enable pattern on the bus in the same frame, and a wrong capture path shows as a read result that differs from what the PHY model drove. A register that accepts writes while busy shows at once as a changed read-back word in the cycle after the stray write.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int DATA_BITS  = FRAME_BITS - DATA_FIRST;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam int POS_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic        req;
        logic        wr;
        logic [3:0]  spare;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic logic [FRAME_BITS-1:0] frame_bits(input mdio_cmd_t c);
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] pay;
        opc = c.wr ? 2'b01 : 2'b10;
        ta  = c.wr ? 2'b10 : 2'b00;
        pay = c.wr ? c.data : 16'h0000;
        return {{PRE_BITS{1'b1}}, 2'b01, opc, c.phy, c.regad, ta, pay};
    endfunction

    function automatic logic [FRAME_BITS-1:0] drive_mask(input mdio_cmd_t c);
        return c.wr ? {FRAME_BITS{1'b1}}
                    : {{TA_FIRST{1'b1}}, {(FRAME_BITS-TA_FIRST){1'b0}}};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic drive_stb,
    output logic sample_stb
);
    localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // first cycle of the low half: launch point; last low cycle: rising edge
    assign drive_stb  = en && !mdc && (cnt == '0);
    assign sample_stb = en && !mdc && (cnt == LAST);

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  mdio_cmd_t   cmd,
    input  logic        drive_stb,
    input  logic        sample_stb,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rx_data
);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(FRAME_BITS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_FIRST + 1);

    logic [IDX_W-1:0]      idx;
    logic [FRAME_BITS-1:0] fr;
    logic [FRAME_BITS-1:0] oe_m;
    logic [POS_W-1:0]      pos;

    assign fr   = frame_bits(cmd);
    assign oe_m = drive_mask(cmd);
    assign pos  = POS_W'(FRAME_BITS - 1) - idx[POS_W-1:0];
    assign done = busy && drive_stb && (idx == END_IDX);

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            if (drive_stb) begin
                if (idx == END_IDX) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    mdio_o  <= fr[pos];
                    mdio_oe <= oe_m[pos];
                end
            end
            if (sample_stb && idx != END_IDX) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
        end else if (busy && sample_stb && !cmd.wr &&
                     idx >= DATA_IDX && idx != END_IDX) begin
            rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
        end
    end

    // R6: line stays released through second turnaround bit and data of a read
    assert_read_release_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd.wr && idx >= TA2_IDX) |-> !mdio_oe);

    // R4: bit counter never runs past the frame length
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (rst)
        idx <= END_IDX);

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   cmd_q;
    logic        busy;
    logic        drive_stb;
    logic        sample_stb;
    logic        done;
    logic [15:0] rx_data;

    assign busy    = cmd_q.req;
    assign rd_data = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (done) begin
            cmd_q.req <= 1'b0;
            if (!cmd_q.wr) begin
                cmd_q.data <= rx_data;
            end
        end else if (wr_en && !cmd_q.req) begin
            cmd_q <= mdio_cmd_t'(wr_data);
        end
    end

    mdc_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk        (clk),
        .rst        (rst),
        .en         (busy),
        .mdc        (mdc),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

    mdio_frame_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .cmd        (cmd_q),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done)  ,
        .rx_data    (rx_data)
    );

    // R1: idle bus whenever no request is pending
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_q.req |-> (!mdio_oe && !mdc));

    // R2: accepted start raises the flag; completion drops it
    assert_start_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmd_q.req && wr_data[31]) |=> cmd_q.req);
    assert_done_clear_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !cmd_q.req);

    // R7: writes during a pending request leave the command fields alone
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.req && !done && wr_en) |=> (cmd_q == $past(cmd_q)));

    // R9: data line and enable only move while MDC is low on both sides
    assert_mdio_low_change_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> (!mdc && !$past(mdc)));

endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
    localparam int CLK_NS   = 10;
    localparam int HALF_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int hi_changes = 0;
    int stray_rises = 0;
    bit ended = 0;

    typedef struct packed {
        logic [63:0] b;
        logic [63:0] m;
        logic [15:0] rv;
        logic        rd;
    } exp_t;
    exp_t sb_q[$];

    int          nb = 0;
    logic [63:0] got_b, got_oe;
    time         last_rise;

    always #(CLK_NS/2) clk = ~clk;

    mdio_cmd_engine #(.HALF_DIV(HALF_DIV)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [15:0] phy_value(input logic [4:0] p, input logic [4:0] r);
        return {p, r, 6'b101101};
    endfunction

    // monitor: rebuild each frame from rising MDC and compare with scoreboard
    always @(posedge mdc) begin
        if (sb_q.size() == 0) begin
            stray_rises++;
        end else begin
            got_b[63-nb]  = mdio_o;
            got_oe[63-nb] = mdio_oe;
            if (nb == 1)
                check(($time - last_rise) == 2*HALF_DIV*CLK_NS, "R9", "mdc period",
                      64'($time - last_rise), 64'(2*HALF_DIV*CLK_NS));
            last_rise = $time;
            nb++;
            if (nb == 64) begin
                check(got_oe == sb_q[0].m, sb_q[0].rd ? "R6" : "R5",
                      "drive enable pattern", got_oe, sb_q[0].m);
                check((got_b & sb_q[0].m) == sb_q[0].b, "R4", "frame bits",
                      got_b & sb_q[0].m, sb_q[0].b);
                void'(sb_q.pop_front());
                nb = 0;
            end
        end
    end

    // PHY model: present read data after each falling MDC of the data phase
    always @(negedge mdc) begin
        if (sb_q.size() > 0 && sb_q[0].rd && nb >= 48 && nb < 64)
            mdio_i = sb_q[0].rv[63-nb];
    end

    always @(mdio_o or mdio_oe) begin
        if (mdc === 1'b1) hi_changes++;
    end

    task automatic run_cmd(input logic [31:0] w, input bit poke);
        exp_t e;
        logic [15:0] rv;
        logic [31:0] exp_rd;
        int wait_n;
        rv      = phy_value(w[25:21], w[20:16]);
        e.rd    = !w[30];
        e.rv    = rv;
        e.b     = {32'hFFFF_FFFF, 2'b01, w[30] ? 2'b01 : 2'b10, w[25:21], w[20:16],
                   w[30] ? 2'b10 : 2'b00, w[30] ? w[15:0] : 16'h0};
        e.m     = w[30] ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
        sb_q.push_back(e);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data[31] == 1'b1, "R2", "busy flag after start", 64'(rd_data), 64'(w));
        if (poke) begin
            repeat (40) @(negedge clk);
            wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
            wr_en = 1'b0;
            check(rd_data == w, "R7", "register after busy write", 64'(rd_data), 64'(w));
        end
        wait_n = 0;
        while (rd_data[31] && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        exp_rd = e.rd ? {1'b0, w[30:16], rv} : {1'b0, w[30:0]};
        check(rd_data == exp_rd, e.rd ? "R6" : "R5", "register after completion",
              64'(rd_data), 64'(exp_rd));
        check(sb_q.size() == 0, "R3", "frame consumed by completion",
              64'(sb_q.size()), 64'(0));
        check(!mdio_oe && !mdc, "R1", "bus idle after completion",
              64'({mdc, mdio_oe}), 64'(0));
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 32'h0 && !mdc && !mdio_oe, "R1", "reset state",
              64'({rd_data, mdc, mdio_oe}), 64'(0));

        run_cmd(32'hC0A0_9000, 0);   // R5 write 0x9000 reg 0 PHY 5
        run_cmd(32'hC0C0_9000, 0);   // R5 PHY 6
        run_cmd(32'h80D1_0000, 0);   // R6 read PHY 6 reg 17
        run_cmd(32'h83FF_ABCD, 0);   // R6 read PHY 31 reg 31, payload overwritten
        run_cmd(32'h8000_0000, 0);   // R6 read PHY 0 reg 0
        run_cmd(32'hC3FF_FFFF, 0);   // R3 extreme fields on write
        run_cmd(32'hC001_0001, 0);   // R3 write PHY 0 reg 1
        run_cmd(32'hC0A0_5A5A, 1);   // R7 write ignored while busy
        run_cmd(32'h8055_0000, 1);   // R7 on a read

        // R8: write without request bit
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h4123_1234;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (100) @(negedge clk);
        check(rd_data == 32'h4123_1234, "R8", "stored word", 64'(rd_data), 64'h4123_1234);
        check(stray_rises == 0 && !mdc && !mdio_oe, "R8", "no frame started",
              64'(stray_rises), 64'(0));
        run_cmd(32'hC0E2_0F0F, 0);   // R2 start works after plain store

        check(hi_changes == 0, "R9", "mdio changes while mdc high",
              64'(hi_changes), 64'(0));
        finish_run();
    end

endmodule